// File: doc/BRIEF.md
# Adaptive Transmit Start Threshold

This block decides when a transmit path may begin sending the frame at the head of its FIFO. It has two ways of making that decision. In threshold mode it gives the go-ahead once the FIFO fill level reaches a byte count picked by a two-bit code. In store-and-forward mode it waits until a whole frame is held in the FIFO, and the fill level plays no part.

When the FIFO runs dry in the middle of a frame, the block recovers on its own. First it halts the transmit process and records the event in two sticky status bits. One cycle later it moves the start point one step higher. One cycle after that it restarts transmission. The steps run through the four byte counts and end in store-and-forward, which is the final step.

Software reaches the block through a single configuration write port. That port carries the run bit, the threshold code and the store-and-forward bit. A separate write-one-to-clear port acknowledges the status bits. The FIFO storage and the framing logic are outside this block.

Top module: `tx_start_thresh`

## Requirements
- R1: After reset, transmission is stopped, the threshold code is 0, store-and-forward is off, both status bits are 0 and tx_start is 0.
- R2: In threshold mode, threshold code c (two bits) means a start point of 128·2^c bytes: 0→128, 1→256, 2→512, 3→1024. The start condition is met while running and fifo_level ≥ that count.
- R3: With store-and-forward set, the start condition is met while running and frame_whole is 1. The threshold code and fifo_level are ignored.
- R4: tx_start is high for exactly one cycle, in the cycle after the clock edge at which the start condition goes from false to true. It stays low while the condition holds and while transmission is stopped.
- R5: When tx_underflow is sampled while running, the next cycle shows running=0, stat_underflow=1 and stat_stopped=1, with the mode not yet changed.
- R6: One cycle after that, the mode moves one step along 128→256→512→1024→store-and-forward. One cycle later still, running returns to 1.
- R7: Once store-and-forward is set, a further underflow still stops and restarts transmission but leaves the mode unchanged. The automatic sequence never clears store-and-forward.
- R8: A configuration write always loads the run bit. It loads the threshold code and store-and-forward bit only if transmission was stopped when the write was sampled.
- R9: A configuration write overrides the automatic sequence in the same cycle. It wins over an underflow in that cycle, and over a pending step or restart, and it cancels whatever was still pending.
- R10: Writing 1 to a status bit through the clear port clears it. An underflow in the same cycle as the clear wins, so the bit stays set.
- R11: An underflow sampled while transmission is stopped changes no status bit, no mode and no run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_level | input | LVL_W | Bytes currently held in the transmit FIFO |
| frame_whole | input | 1 | A complete frame is held in the FIFO |
| tx_underflow | input | 1 | One-cycle strobe: the FIFO ran dry mid-frame |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_run | input | 1 | Run bit value to write (1 = transmit, 0 = stop) |
| cfg_thr | input | 2 | Threshold code to write |
| cfg_sf | input | 1 | Store-and-forward bit to write |
| clr_we | input | 1 | Status clear strobe |
| clr_underflow | input | 1 | Write-one-to-clear for stat_underflow |
| clr_stopped | input | 1 | Write-one-to-clear for stat_stopped |
| tx_start | output | 1 | One-cycle go-ahead for the head frame |
| running | output | 1 | Transmit process is running |
| stat_underflow | output | 1 | Sticky underflow status |
| stat_stopped | output | 1 | Sticky process-stopped status |
| cur_thr | output | 2 | Current threshold code |
| cur_sf | output | 1 | Current store-and-forward bit |

## Verification
Most internal faults reach the ports within one to three cycles of an underflow. A wrong step in the escalation shows up on cur_thr and cur_sf two edges after the strobe. A restart that never comes, or one that fires too early, shows up on running three edges after the strobe. A bad start-condition state appears differently. A stale edge detector either repeats tx_start while the level is held or leaves it out at a crossing, and a wrong byte count moves the crossing point. The bench therefore sweeps every mode across the exact level and frame_whole boundaries, and it samples each cycle of the stop, step and restart sequence.

// File: rtl/tst_pkg.sv
package tst_pkg;
    localparam int THR_W = 2;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_STEP    = 2'd1,
        SEQ_RESTART = 2'd2
    } seq_e;

    typedef struct packed {
        logic             sf;
        logic [THR_W-1:0] thr;
    } mode_t;

    typedef struct packed {
        mode_t mode;
        logic  run;
        seq_e  seq;
        logic  st_unf;
        logic  st_stop;
        logic  cond;
        logic  start;
    } state_t;
endpackage

// File: rtl/tst_level_cmp.sv
module tst_level_cmp
    import tst_pkg::*;
#(
    parameter int LVL_W      = 11,
    parameter int BASE_BYTES = 128
) (
    input  mode_t            mode,
    input  logic             run,
    input  logic [LVL_W-1:0] level,
    input  logic             whole,
    output logic             cond
);
    localparam int CW = LVL_W + 1;

    logic [CW-1:0] need;
    logic          lvl_ok;

    always_comb begin
        need   = CW'(BASE_BYTES) << mode.thr;
        lvl_ok = {1'b0, level} >= need;
        cond   = run & (mode.sf ? whole : lvl_ok);
    end
endmodule

// File: rtl/tst_escalate.sv
module tst_escalate
    import tst_pkg::*;
(
    input  mode_t cur,
    output mode_t nxt
);
    always_comb begin
        nxt = cur;
        if (!cur.sf) begin
            if (cur.thr == '1) begin
                nxt.sf = 1'b1;
            end else begin
                nxt.thr = cur.thr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tx_start_thresh.sv
module tx_start_thresh
    import tst_pkg::*;
#(
    parameter int LVL_W      = 11,
    parameter int BASE_BYTES = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             frame_whole,
    input  logic             tx_underflow,
    input  logic             cfg_we,
    input  logic             cfg_run,
    input  logic [THR_W-1:0] cfg_thr,
    input  logic             cfg_sf,
    input  logic             clr_we,
    input  logic             clr_underflow,
    input  logic             clr_stopped,
    output logic             tx_start,
    output logic             running,
    output logic             stat_underflow,
    output logic             stat_stopped,
    output logic [THR_W-1:0] cur_thr,
    output logic             cur_sf
);
    state_t q, d;
    logic   cond;
    mode_t  esc_mode;

    tst_level_cmp #(
        .LVL_W      (LVL_W),
        .BASE_BYTES (BASE_BYTES)
    ) u_cmp (
        .mode  (q.mode),
        .run   (q.run),
        .level (fifo_level),
        .whole (frame_whole),
        .cond  (cond)
    );

    tst_escalate u_esc (
        .cur (q.mode),
        .nxt (esc_mode)
    );

    always_comb begin
        d       = q;
        d.cond  = cond;
        d.start = cond & ~q.cond;

        // automatic stop / step / restart sequence
        case (q.seq)
            SEQ_STEP: begin
                d.mode = esc_mode;
                d.seq  = SEQ_RESTART;
            end
            SEQ_RESTART: begin
                d.run = 1'b1;
                d.seq = SEQ_IDLE;
            end
            default: d.seq = SEQ_IDLE;
        endcase

        // acknowledge first, so a same-cycle event stays visible
        if (clr_we) begin
            if (clr_underflow) d.st_unf  = 1'b0;
            if (clr_stopped)   d.st_stop = 1'b0;
        end

        if (tx_underflow && q.run) begin
            d.run     = 1'b0;
            d.st_unf  = 1'b1;
            d.st_stop = 1'b1;
            d.seq     = SEQ_STEP;
        end

        // software write wins over everything automatic
        if (cfg_we) begin
            d.run = cfg_run;
            if (!q.run) begin
                d.mode.thr = cfg_thr;
                d.mode.sf  = cfg_sf;
            end
            d.seq = SEQ_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign tx_start       = q.start;
    assign running        = q.run;
    assign stat_underflow = q.st_unf;
    assign stat_stopped   = q.st_stop;
    assign cur_thr        = q.mode.thr;
    assign cur_sf         = q.mode.sf;
endmodule

// File: rtl/tst_checker.sv
module tst_checker #(
    parameter int THR_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_start,
    input logic             running,
    input logic             tx_underflow,
    input logic             cfg_we,
    input logic             stat_underflow,
    input logic             stat_stopped,
    input logic [THR_W-1:0] cur_thr,
    input logic             cur_sf
);
    // R4
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    // R4
    start_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(running));

    // R5
    unf_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tx_underflow && !cfg_we) |=> (!running && stat_underflow && stat_stopped));

    // R8
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({cur_sf, cur_thr}) |-> !$past(running));

    // R7
    sf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_sf && !cfg_we) |=> cur_sf);
endmodule

bind tx_start_thresh tst_checker #(.THR_W(tst_pkg::THR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tx_start       (tx_start),
    .running        (running),
    .tx_underflow   (tx_underflow),
    .cfg_we         (cfg_we),
    .stat_underflow (stat_underflow),
    .stat_stopped   (stat_stopped),
    .cur_thr        (cur_thr),
    .cur_sf         (cur_sf)
);

// File: tb/tb_tx_start_thresh.sv
module tb_tx_start_thresh;
    localparam int LVL_W = 11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LVL_W-1:0] fifo_level = '0;
    logic             frame_whole = 1'b0;
    logic             tx_underflow = 1'b0;
    logic             cfg_we = 1'b0;
    logic             cfg_run = 1'b0;
    logic [1:0]       cfg_thr = '0;
    logic             cfg_sf = 1'b0;
    logic             clr_we = 1'b0;
    logic             clr_underflow = 1'b0;
    logic             clr_stopped = 1'b0;
    logic             tx_start, running, stat_underflow, stat_stopped, cur_sf;
    logic [1:0]       cur_thr;

    int compared = 0;
    int mismatched = 0;

    always #2 clk = ~clk;

    tx_start_thresh #(.LVL_W(LVL_W), .BASE_BYTES(128)) dut (
        .clk, .rst_n, .fifo_level, .frame_whole, .tx_underflow,
        .cfg_we, .cfg_run, .cfg_thr, .cfg_sf,
        .clr_we, .clr_underflow, .clr_stopped,
        .tx_start, .running, .stat_underflow, .stat_stopped, .cur_thr, .cur_sf
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int got, input int exp);
        compared++;
        if (got != exp) begin
            mismatched++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic cfg(input logic r, input logic [1:0] t, input logic s);
        cfg_we = 1'b1; cfg_run = r; cfg_thr = t; cfg_sf = s;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic clear_all();
        clr_we = 1'b1; clr_underflow = 1'b1; clr_stopped = 1'b1;
        tick();
        clr_we = 1'b0; clr_underflow = 1'b0; clr_stopped = 1'b0;
    endtask

    function automatic int enc(input int step);
        return (step >= 4) ? 7 : step;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: got hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 running", int'(running), 0);
        chk("R1 thr", int'(cur_thr), 0);
        chk("R1 sf", int'(cur_sf), 0);
        chk("R1 stat_underflow", int'(stat_underflow), 0);
        chk("R1 stat_stopped", int'(stat_stopped), 0);
        chk("R1 tx_start", int'(tx_start), 0);

        // R2 / R3 / R4 sweep over every mode
        for (int code = 0; code < 4; code++) begin
            for (int s = 0; s < 2; s++) begin
                int thr_bytes;
                thr_bytes = 128 << code;
                fifo_level = '0; frame_whole = 1'b0;
                cfg(1'b0, 2'(code), 1'(s));
                chk("R8 thr load while stopped", int'(cur_thr), code);
                chk("R8 sf load while stopped", int'(cur_sf), s);
                cfg(1'b1, 2'(code), 1'(s));
                chk("R8 run set", int'(running), 1);
                if (s == 0) begin
                    fifo_level = LVL_W'(thr_bytes - 1);
                    tick();
                    chk("R2 below threshold", int'(tx_start), 0);
                    fifo_level = LVL_W'(thr_bytes);
                    tick();
                    chk("R2 at threshold", int'(tx_start), 1);
                    tick();
                    chk("R4 held no repeat", int'(tx_start), 0);
                    fifo_level = '1;
                    tick();
                    chk("R4 higher no repeat", int'(tx_start), 0);
                    fifo_level = LVL_W'(thr_bytes - 1);
                    tick();
                    chk("R4 drop", int'(tx_start), 0);
                    fifo_level = LVL_W'(thr_bytes + 5);
                    tick();
                    chk("R4 second crossing", int'(tx_start), 1);
                end else begin
                    fifo_level = '1;
                    tick();
                    chk("R3 level ignored", int'(tx_start), 0);
                    frame_whole = 1'b1;
                    tick();
                    chk("R3 whole frame", int'(tx_start), 1);
                    tick();
                    chk("R4 sf held", int'(tx_start), 0);
                    frame_whole = 1'b0;
                    tick();
                end
                cfg(1'b0, 2'(code), 1'(s));
            end
        end

        // R4 stopped gives no start
        cfg(1'b0, 2'd0, 1'b0);
        fifo_level = '1; frame_whole = 1'b1;
        tick(); tick();
        chk("R4 stopped no start", int'(tx_start), 0);
        fifo_level = '0; frame_whole = 1'b0;
        tick();

        // R5 / R6 / R7 escalation chain
        cfg(1'b1, 2'd0, 1'b0);
        for (int i = 0; i < 6; i++) begin
            int nstep;
            nstep = (i + 1 > 4) ? 4 : i + 1;
            tx_underflow = 1'b1;
            tick();
            tx_underflow = 1'b0;
            chk("R5 stopped", int'(running), 0);
            chk("R5 stat_underflow", int'(stat_underflow), 1);
            chk("R5 stat_stopped", int'(stat_stopped), 1);
            chk("R5 mode unchanged yet", int'({cur_sf, cur_thr}), enc(i));
            tick();
            if (i >= 4) chk("R7 sf unchanged", int'({cur_sf, cur_thr}), enc(nstep));
            else        chk("R6 step", int'({cur_sf, cur_thr}), enc(nstep));
            chk("R6 still stopped", int'(running), 0);
            tick();
            chk("R6 restart", int'(running), 1);
            clear_all();
            chk("R10 clear unf", int'(stat_underflow), 0);
            chk("R10 clear stop", int'(stat_stopped), 0);
        end

        // R8 mode locked while running
        cfg(1'b1, 2'd1, 1'b0);
        chk("R8 locked while running", int'({cur_sf, cur_thr}), 7);
        cfg(1'b0, 2'd1, 1'b0);
        chk("R8 stop accepted", int'(running), 0);
        chk("R8 mode kept on stopping write", int'({cur_sf, cur_thr}), 7);
        cfg(1'b0, 2'd1, 1'b0);
        chk("R8 load after stop", int'({cur_sf, cur_thr}), 1);

        // R9 write wins over same-cycle underflow
        cfg(1'b1, 2'd1, 1'b0);
        tx_underflow = 1'b1;
        cfg(1'b1, 2'd1, 1'b0);
        tx_underflow = 1'b0;
        chk("R9 write keeps running", int'(running), 1);
        chk("R9 stat still recorded", int'(stat_underflow), 1);
        tick(); tick();
        chk("R9 no escalation", int'({cur_sf, cur_thr}), 1);
        chk("R9 still running", int'(running), 1);
        // R9 write wins over pending step
        tx_underflow = 1'b1;
        tick();
        tx_underflow = 1'b0;
        cfg(1'b0, 2'd0, 1'b0);
        chk("R9 write over step", int'({cur_sf, cur_thr}), 0);
        chk("R9 stopped by write", int'(running), 0);
        tick();
        chk("R9 restart cancelled", int'(running), 0);
        chk("R9 mode kept", int'({cur_sf, cur_thr}), 0);

        // R10 set wins over clear, separate clears
        clear_all();
        cfg(1'b1, 2'd0, 1'b0);
        tx_underflow = 1'b1;
        clr_we = 1'b1; clr_underflow = 1'b1; clr_stopped = 1'b1;
        tick();
        tx_underflow = 1'b0;
        clr_we = 1'b0; clr_underflow = 1'b0; clr_stopped = 1'b0;
        chk("R10 set wins unf", int'(stat_underflow), 1);
        chk("R10 set wins stop", int'(stat_stopped), 1);
        tick(); tick();
        clr_we = 1'b1; clr_underflow = 1'b1;
        tick();
        clr_we = 1'b0; clr_underflow = 1'b0;
        chk("R10 only unf cleared", int'(stat_underflow), 0);
        chk("R10 stop untouched", int'(stat_stopped), 1);
        clr_we = 1'b1; clr_stopped = 1'b1;
        tick();
        clr_we = 1'b0; clr_stopped = 1'b0;
        chk("R10 stop cleared", int'(stat_stopped), 0);

        // R11 underflow while stopped
        cfg(1'b0, 2'd0, 1'b0);
        cfg(1'b0, 2'd0, 1'b0);
        tx_underflow = 1'b1;
        tick();
        tx_underflow = 1'b0;
        chk("R11 no unf status", int'(stat_underflow), 0);
        chk("R11 no stop status", int'(stat_stopped), 0);
        tick(); tick();
        chk("R11 mode unchanged", int'({cur_sf, cur_thr}), 0);
        chk("R11 not restarted", int'(running), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule